// File: doc/BRIEF.md
# DMA Page Translation Unit

This block stands between DMA-capable devices and physical memory. Every device transfer address is mapped to a 32-bit physical address through a table of page descriptors kept in internal registers. The input space is 24 bits wide and cut into 8 KiB pages, so 2048 descriptors cover it. The translated address takes bits 31..13 from the chosen descriptor, and bits 12..0 pass straight through from the input address.

A device narrower than 24 bits is wired to the top of the input space: the missing upper input bits read as one. Each descriptor holds a type code, write protect, used, modified, a whole-block flag and a cache-inhibit flag. The type code tells an unmapped page apart from a malformed descriptor. A request that breaks a rule is refused with a fault code. The first fault is held, together with its 24-bit input address, until the CPU clears it.

A CPU-side port reads and writes whole descriptors by index. A DMA port takes one request per cycle under a valid/ready handshake and answers exactly one clock later.

Top module: `dma_xlate_unit`

## Requirements
- R1: After reset, every descriptor reads as 0 (unmapped), `rsp_valid_o` is 0 and `fault_code_o` is 0.
- R2: An accepted request that is granted gives `rsp_paddr_o = {desc[31:13], in_addr[12:0]}` with `rsp_valid_o=1` and `rsp_grant_o=1` on the clock after acceptance. `req_ready_o` is always 1.
- R3: With a device address width DEV_AW, the 24-bit input address is `{ones, req_addr_i}`. The descriptor index is input bits 23..13, so a 16-bit device reaches only indices 2040..2047.
- R4: Type code desc[1:0]=00 faults with code 2 (unmapped). desc[1]=1 faults with code 1 (illegal descriptor). Only 01 can be granted.
- R5: Write protect (desc bit 2) refuses a write with code 3 and leaves reads granted.
- R6: The whole-block flag (desc bit 5) refuses any transfer whose byte length is not a multiple of 16, with code 4.
- R7: When several faults apply, the reported one follows this priority: illegal (1), then unmapped (2), then protect (3), then block size (4).
- R8: `rsp_ci_o` equals desc bit 6 on a granted response and is 0 on a fault.
- R9: A granted access sets the used bit (desc bit 3). A granted write also sets the modified bit (desc bit 4). A faulted access changes neither bit.
- R10: The first fault latches its code on `fault_code_o` and its 24-bit input address on `fault_addr_o`. Later faults do not replace it. `fault_clr_i` returns the code to 0, but a fault arriving in the same cycle as the clear is captured.
- R11: Descriptor bits 12..7 are not stored and read back as 0.
- R12: A CPU write to the entry looked up in the same cycle does not affect that lookup. It is seen by the next request, and it wins over that cycle's used/modified update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cpu_we_i | input | 1 | Descriptor write strobe |
| cpu_idx_i | input | 11 | Descriptor index for read and write |
| cpu_wdata_i | input | 32 | Descriptor write data |
| cpu_rdata_o | output | 32 | Descriptor at cpu_idx_i (combinational) |
| fault_clr_i | input | 1 | Clear the latched fault |
| req_valid_i | input | 1 | DMA request valid |
| req_ready_o | output | 1 | DMA request ready |
| req_addr_i | input | DEV_AW | Device transfer address |
| req_write_i | input | 1 | 1 = write to memory |
| req_len_i | input | LEN_W | Transfer length in bytes |
| rsp_valid_o | output | 1 | Response valid, one clock after accept |
| rsp_grant_o | output | 1 | Access granted |
| rsp_paddr_o | output | 32 | Translated physical address |
| rsp_ci_o | output | 1 | Access is uncacheable |
| rsp_fault_o | output | 3 | Fault code for this response, 0 if granted |
| fault_code_o | output | 3 | Latched first fault code |
| fault_addr_o | output | 24 | Latched 24-bit input address of that fault |

## Verification
The bench builds the block with DEV_AW=16 and LEN_W=8. The narrow device address then exercises top alignment: every request must land in descriptor indices 2040..2047, and the latched fault address carries ones in bits 23..16. The 8-bit length gives lengths both on and off 16-byte multiples. The full 2048-entry table stays in place, so the CPU port's reads and writes can be checked against the same entries that the DMA path updates.

// File: rtl/dxu_pkg.sv
package dxu_pkg;
  typedef enum logic [2:0] {
    FLT_NONE     = 3'd0,
    FLT_ILLEGAL  = 3'd1,
    FLT_UNMAPPED = 3'd2,
    FLT_PROTECT  = 3'd3,
    FLT_BLOCK    = 3'd4
  } fault_e;

  localparam int ATTR_W = 7;
  localparam int B_WP   = 2;
  localparam int B_USED = 3;
  localparam int B_MOD  = 4;
  localparam int B_BLK  = 5;
  localparam int B_CI   = 6;
  localparam int BLK_BYTES_LOG2 = 4;
endpackage

// File: rtl/dxu_desc_table.sv
module dxu_desc_table
  import dxu_pkg::*;
#(
  parameter int IDX_W      = 11,
  parameter int PA_W       = 32,
  parameter int PAGE_SHIFT = 13
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cpu_we_i,
  input  logic [IDX_W-1:0]      cpu_idx_i,
  input  logic [PA_W-1:0]       cpu_wdata_i,
  output logic [PA_W-1:0]       cpu_rdata_o,
  input  logic [IDX_W-1:0]      lk_idx_i,
  output logic [PA_W-PAGE_SHIFT-1:0] lk_frame_o,
  output logic [ATTR_W-1:0]     lk_attr_o,
  input  logic                  upd_i,
  input  logic                  upd_wr_i
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int FRAME_W = PA_W - PAGE_SHIFT;
  localparam int GAP_W   = PAGE_SHIFT - ATTR_W;

  logic [FRAME_W-1:0] frame_q [ENTRIES];
  logic [ATTR_W-1:0]  attr_q  [ENTRIES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENTRIES; i++) begin
        frame_q[i] <= '0;
        attr_q[i]  <= '0;
      end
    end else begin
      if (upd_i) begin
        attr_q[lk_idx_i][B_USED] <= 1'b1;
        if (upd_wr_i) attr_q[lk_idx_i][B_MOD] <= 1'b1;
      end
      // CPU write placed last so it overrides a same-cycle flag update
      if (cpu_we_i) begin
        frame_q[cpu_idx_i] <= cpu_wdata_i[PA_W-1:PAGE_SHIFT];
        attr_q[cpu_idx_i]  <= cpu_wdata_i[ATTR_W-1:0];
      end
    end
  end

  assign cpu_rdata_o = {frame_q[cpu_idx_i], {GAP_W{1'b0}}, attr_q[cpu_idx_i]};
  assign lk_frame_o  = frame_q[lk_idx_i];
  assign lk_attr_o   = attr_q[lk_idx_i];

  assert_used_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !(cpu_we_i && cpu_idx_i == lk_idx_i)) |=> attr_q[$past(lk_idx_i)][B_USED]);

  assert_cpu_wins_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_we_i |=> attr_q[$past(cpu_idx_i)] == $past(cpu_wdata_i[ATTR_W-1:0]));
endmodule

// File: rtl/dxu_check.sv
module dxu_check
  import dxu_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic [ATTR_W-1:0] attr_i,
  input  logic              write_i,
  input  logic [LEN_W-1:0]  len_i,
  output fault_e            fault_o
);
  logic odd_len;
  assign odd_len = |len_i[BLK_BYTES_LOG2-1:0];

  always_comb begin
    if (attr_i[1])                           fault_o = FLT_ILLEGAL;
    else if (!attr_i[0])                     fault_o = FLT_UNMAPPED;
    else if (write_i && attr_i[B_WP])        fault_o = FLT_PROTECT;
    else if (attr_i[B_BLK] && odd_len)       fault_o = FLT_BLOCK;
    else                                     fault_o = FLT_NONE;
  end

  always_comb begin
    assert_grant_valid_dt_R4: assert ((fault_o != FLT_NONE) || (attr_i[1:0] == 2'b01));
  end
endmodule

// File: rtl/dxu_fault_log.sv
module dxu_fault_log
  import dxu_pkg::*;
#(
  parameter int IN_AW = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             capture_i,
  input  fault_e           code_i,
  input  logic [IN_AW-1:0] addr_i,
  input  logic             clr_i,
  output logic [2:0]       code_o,
  output logic [IN_AW-1:0] addr_o
);
  fault_e           code_q;
  logic [IN_AW-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= FLT_NONE;
      addr_q <= '0;
    end else if (capture_i && (code_q == FLT_NONE || clr_i)) begin
      code_q <= code_i;
      addr_q <= addr_i;
    end else if (clr_i) begin
      code_q <= FLT_NONE;
    end
  end

  assign code_o = code_q;
  assign addr_o = addr_q;

  assert_fault_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_q != FLT_NONE && !clr_i) |=> ($stable(code_q) && $stable(addr_q)));
endmodule

// File: rtl/dma_xlate_unit.sv
module dma_xlate_unit
  import dxu_pkg::*;
#(
  parameter int IN_AW      = 24,
  parameter int PAGE_SHIFT = 13,
  parameter int PA_W       = 32,
  parameter int DEV_AW     = 24,
  parameter int LEN_W      = 16
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        cpu_we_i,
  input  logic [IN_AW-PAGE_SHIFT-1:0] cpu_idx_i,
  input  logic [PA_W-1:0]             cpu_wdata_i,
  output logic [PA_W-1:0]             cpu_rdata_o,
  input  logic                        fault_clr_i,
  input  logic                        req_valid_i,
  output logic                        req_ready_o,
  input  logic [DEV_AW-1:0]           req_addr_i,
  input  logic                        req_write_i,
  input  logic [LEN_W-1:0]            req_len_i,
  output logic                        rsp_valid_o,
  output logic                        rsp_grant_o,
  output logic [PA_W-1:0]             rsp_paddr_o,
  output logic                        rsp_ci_o,
  output logic [2:0]                  rsp_fault_o,
  output logic [2:0]                  fault_code_o,
  output logic [IN_AW-1:0]            fault_addr_o
);
  localparam int IDX_W   = IN_AW - PAGE_SHIFT;
  localparam int FRAME_W = PA_W - PAGE_SHIFT;
  localparam int PAD_W   = IN_AW - DEV_AW;

  logic [IN_AW-1:0]   eff_addr;
  logic [IDX_W-1:0]   lk_idx;
  logic [FRAME_W-1:0] lk_frame;
  logic [ATTR_W-1:0]  lk_attr;
  fault_e             lk_fault;
  logic               accept, grant;

  generate
    if (PAD_W > 0) begin : g_pad
      assign eff_addr = {{PAD_W{1'b1}}, req_addr_i};
    end else begin : g_full
      assign eff_addr = req_addr_i;
    end
  endgenerate

  assign req_ready_o = 1'b1;
  assign accept      = req_valid_i && req_ready_o;
  assign lk_idx      = eff_addr[IN_AW-1:PAGE_SHIFT];
  assign grant       = accept && (lk_fault == FLT_NONE);

  dxu_desc_table #(.IDX_W(IDX_W), .PA_W(PA_W), .PAGE_SHIFT(PAGE_SHIFT)) u_table (
    .clk_i, .rst_ni, .cpu_we_i, .cpu_idx_i, .cpu_wdata_i, .cpu_rdata_o,
    .lk_idx_i(lk_idx), .lk_frame_o(lk_frame), .lk_attr_o(lk_attr),
    .upd_i(grant), .upd_wr_i(req_write_i)
  );

  dxu_check #(.LEN_W(LEN_W)) u_check (
    .attr_i(lk_attr), .write_i(req_write_i), .len_i(req_len_i), .fault_o(lk_fault)
  );

  dxu_fault_log #(.IN_AW(IN_AW)) u_flog (
    .clk_i, .rst_ni, .capture_i(accept && lk_fault != FLT_NONE), .code_i(lk_fault),
    .addr_i(eff_addr), .clr_i(fault_clr_i), .code_o(fault_code_o), .addr_o(fault_addr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_grant_o <= 1'b0;
      rsp_paddr_o <= '0;
      rsp_ci_o    <= 1'b0;
      rsp_fault_o <= '0;
    end else begin
      rsp_valid_o <= accept;
      if (accept) begin
        rsp_grant_o <= grant;
        rsp_paddr_o <= {lk_frame, eff_addr[PAGE_SHIFT-1:0]};
        rsp_ci_o    <= grant && lk_attr[B_CI];
        rsp_fault_o <= lk_fault;
      end
    end
  end

  assert_rsp_next_cycle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o == $past(accept));

  assert_offset_passthru_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> rsp_paddr_o[PAGE_SHIFT-1:0] == $past(req_addr_i[PAGE_SHIFT-1:0]));

  assert_grant_iff_nofault_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (rsp_grant_o == (rsp_fault_o == 3'd0)));

  assert_ci_only_on_grant_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_grant_o) |-> !rsp_ci_o);
endmodule

// File: tb/dma_xlate_unit_bench.sv
module dma_xlate_unit_bench;
  localparam int DEV_AW = 16;
  localparam int LEN_W  = 8;
  localparam int BASE   = 2040;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_we = 1'b0;
  logic [10:0] cpu_idx = '0;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic        fault_clr = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [7:0]  req_len = '0;
  logic        rsp_valid, rsp_grant, rsp_ci;
  logic [31:0] rsp_paddr;
  logic [2:0]  rsp_fault, fault_code;
  logic [23:0] fault_addr;

  int errors = 0;
  int checks = 0;
  logic [31:0] mdl [8];

  always #2.5 clk = ~clk;

  dma_xlate_unit #(.DEV_AW(DEV_AW), .LEN_W(LEN_W)) u_dma_xlate_unit (
    .clk_i(clk), .rst_ni(rst_n), .cpu_we_i(cpu_we), .cpu_idx_i(cpu_idx),
    .cpu_wdata_i(cpu_wdata), .cpu_rdata_o(cpu_rdata), .fault_clr_i(fault_clr),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_addr_i(req_addr),
    .req_write_i(req_write), .req_len_i(req_len), .rsp_valid_o(rsp_valid),
    .rsp_grant_o(rsp_grant), .rsp_paddr_o(rsp_paddr), .rsp_ci_o(rsp_ci),
    .rsp_fault_o(rsp_fault), .fault_code_o(fault_code), .fault_addr_o(fault_addr)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic cpu_write(input int idx, input logic [31:0] d);
    @(negedge clk);
    cpu_we = 1'b1; cpu_idx = 11'(idx); cpu_wdata = d;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic cpu_read(input string tag, input int idx, input logic [31:0] exp);
    @(negedge clk);
    cpu_idx = 11'(idx);
    #1;
    chk(tag, cpu_rdata, exp);
  endtask

  // drive at negedge, accepted at next posedge, sampled at the following negedge
  task automatic dma(input logic [15:0] a, input logic w, input logic [7:0] l);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = w; req_len = l;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic clear_fault();
    @(negedge clk);
    fault_clr = 1'b1;
    @(negedge clk);
    fault_clr = 1'b0;
  endtask

  // {addr[15:0], write, len[7:0], expected fault[2:0]}
  localparam logic [27:0] VEC [12] = '{
    {16'h0123, 1'b0, 8'd4,  3'd0},   // R2 R8 grant, ci
    {16'h1FFF, 1'b1, 8'd7,  3'd0},   // R2 R9 grant write
    {16'h2010, 1'b0, 8'd4,  3'd2},   // R4 unmapped
    {16'h4000, 1'b1, 8'd3,  3'd1},   // R7 illegal over protect
    {16'h6004, 1'b0, 8'd1,  3'd0},   // R5 read of protected page
    {16'h6008, 1'b1, 8'd16, 3'd3},   // R5 protected write
    {16'h8000, 1'b0, 8'd32, 3'd0},   // R6 multiple of 16
    {16'h8000, 1'b1, 8'd17, 3'd4},   // R6 bad length
    {16'hA000, 1'b1, 8'd5,  3'd3},   // R7 protect over block
    {16'hA000, 1'b0, 8'd5,  3'd4},   // R6 block on read
    {16'hC000, 1'b0, 8'd16, 3'd1},   // R4 code 11 illegal
    {16'hE000, 1'b0, 8'd0,  3'd2}    // R1 R3 untouched entry unmapped
  };

  initial begin : watchdog
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    mdl[0] = 32'h1234_6041; mdl[1] = 32'h0000_0000;
    mdl[2] = 32'hAAAA_A006; mdl[3] = 32'h5555_4005;
    mdl[4] = 32'h0F0F_0021; mdl[5] = 32'h7777_6025;
    mdl[6] = 32'h0000_0003; mdl[7] = 32'h0000_0000;

    repeat (3) @(negedge clk);
    #1;
    chk("R1 rsp_valid", 32'(rsp_valid), 0);
    chk("R1 fault_code", 32'(fault_code), 0);
    chk("R2 ready", 32'(req_ready), 1);
    @(negedge clk);
    rst_n = 1'b1;
    cpu_read("R1 table reset", BASE, 32'h0);

    for (int p = 0; p < 7; p++) cpu_write(BASE + p, mdl[p]);

    for (int v = 0; v < 12; v++) begin
      logic [15:0] a;
      logic [2:0]  ef;
      int          pg;
      a  = VEC[v][27:12];
      ef = VEC[v][2:0];
      pg = int'(a[15:13]);
      dma(a, VEC[v][11], VEC[v][10:3]);
      chk($sformatf("R2 vec%0d valid", v), 32'(rsp_valid), 1);
      chk($sformatf("R7 vec%0d fault", v), 32'(rsp_fault), 32'(ef));
      chk($sformatf("R4 vec%0d grant", v), 32'(rsp_grant), 32'(ef == 3'd0));
      chk($sformatf("R8 vec%0d ci", v), 32'(rsp_ci), 32'((ef == 3'd0) && mdl[pg][6]));
      if (ef == 3'd0)
        chk($sformatf("R3 vec%0d paddr", v), rsp_paddr, {mdl[pg][31:13], a[12:0]});
      @(negedge clk);
      chk($sformatf("R2 vec%0d one beat", v), 32'(rsp_valid), 0);
    end

    chk("R10 first code", 32'(fault_code), 2);
    chk("R3 R10 first addr", 32'(fault_addr), 32'hFF2010);
    clear_fault();
    chk("R10 cleared", 32'(fault_code), 0);

    cpu_read("R9 used+mod", BASE + 0, 32'h1234_6059);
    cpu_read("R9 used only", BASE + 3, 32'h5555_400D);
    cpu_read("R9 faulted untouched", BASE + 5, 32'h7777_6025);
    cpu_read("R9 block page used", BASE + 4, 32'h0F0F_0029);
    cpu_read("R9 illegal untouched", BASE + 2, 32'hAAAA_A006);

    cpu_write(BASE + 7, 32'hFFFF_FFFF);
    cpu_read("R11 unused zero", BASE + 7, 32'hFFFF_E07F);

    // R12: collision, lookup sees old (illegal) contents
    @(negedge clk);
    cpu_we = 1'b1; cpu_idx = 11'(BASE + 7); cpu_wdata = 32'h2222_2001;
    req_valid = 1'b1; req_addr = 16'hE010; req_write = 1'b0; req_len = 8'd0;
    @(negedge clk);
    cpu_we = 1'b0; req_valid = 1'b0;
    chk("R12 old contents used", 32'(rsp_fault), 1);
    dma(16'hE010, 1'b0, 8'd0);
    chk("R12 new contents next", rsp_paddr, 32'h2222_2010);
    chk("R12 new grant", 32'(rsp_grant), 1);
    cpu_read("R12 used after grant", BASE + 7, 32'h2222_2009);

    // R12: CPU write wins over same-cycle used update
    @(negedge clk);
    cpu_we = 1'b1; cpu_idx = 11'(BASE + 7); cpu_wdata = 32'h3333_2001;
    req_valid = 1'b1; req_addr = 16'hE004; req_write = 1'b1; req_len = 8'd0;
    @(negedge clk);
    cpu_we = 1'b0; req_valid = 1'b0;
    chk("R12 old frame granted", rsp_paddr, 32'h2222_2004);
    cpu_read("R12 cpu write wins", BASE + 7, 32'h3333_2001);

    // R10: later fault does not replace held one; capture beats clear
    clear_fault();
    dma(16'h6100, 1'b1, 8'd16);
    dma(16'h8000, 1'b0, 8'd1);
    chk("R10 held code", 32'(fault_code), 3);
    chk("R10 held addr", 32'(fault_addr), 32'hFF6100);
    @(negedge clk);
    fault_clr = 1'b1;
    req_valid = 1'b1; req_addr = 16'h2000; req_write = 1'b0; req_len = 8'd0;
    @(negedge clk);
    fault_clr = 1'b0; req_valid = 1'b0;
    chk("R10 capture on clear", 32'(fault_code), 2);
    chk("R10 capture addr", 32'(fault_addr), 32'hFF2000);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule